// File: doc/BRIEF.md
# Guarded Configuration Byte Sequencer

This block holds one byte-wide configuration register inside a serial memory device and decides, one bus byte at a time, whether the two-wire bus master may see or change it. A bit-level front end hands it single-cycle events: a start or repeated start, each byte received from the master, a request for a byte to send back, and a stop. The block answers each received byte with an acknowledge or a refusal. It serves one-byte random reads of the register. For a write, it runs a three-step arming procedure before it lets a new value through to the nonvolatile back end.

The register sits at word address FFFFh. From bit 7 down, the bits are: write-protect enable, two watchdog select bits, two block-protect bits, the register-arm latch, the write-arm latch, and a third block-protect bit. The two arm latches are volatile and are never part of the stored image. The other six bits persist. A store is triggered only by the stop that ends a write transaction, and it fires one strobe carrying the persistent image to the back end. While the back end reports that it is busy, the block refuses every new transaction.

Top module: `cfg_guard_seq`

## Requirements
- R1: After reset, `cfg_q` equals `INIT_IMG` with bits 2 and 1 cleared, and `ack_vld`, `rd_vld` and `store_go` are low.
- R2: The first byte after a start is acknowledged only when bits 7:1 equal `DEV_ID`, `nv_busy` is low, and either bit 0 (read) is 0 or a repeated start followed a completed FFFFh address phase. Once that byte is refused, every byte is refused until the next start.
- R3: Both word-address bytes are always acknowledged. If the address is not FFFFh, the data bytes that follow are refused and the stop leaves the register unchanged.
- R4: After address FFFFh, the first data byte is always acknowledged and any further data bytes in the same transaction are refused.
- R5: A stop after the data byte 02h sets the write-arm latch, which reads back as bit 1.
- R6: A stop after the data byte 06h sets the register-arm latch, which reads back as bit 2, only if the write-arm latch is already set. Otherwise it has no effect.
- R7: With both latches set, the stop after a data byte raises `store_go` for exactly one cycle. `store_img` and the persistent bits of `cfg_q` take the byte with bits 2:1 cleared, and both latches clear.
- R8: With the latches not both set, any data byte other than 02h or 06h leaves `cfg_q` unchanged and fires no store.
- R9: A stop before the data byte, or a repeated start after it, ends the write without a store and leaves both latches as they were.
- R10: After an FFFFh address phase, a repeated start and an acknowledged read select byte, the next read request returns `cfg_q` (latch bits included) on `rd_data` with a one-cycle `rd_vld`. The block is then idle: further read requests return nothing and further bytes are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start or repeated start seen on the bus |
| ev_stop | input | 1 | Stop seen on the bus |
| ev_byte | input | 1 | A byte from the master is in `rx_byte` |
| rx_byte | input | 8 | Received byte |
| ev_rdreq | input | 1 | Master wants one byte from the device |
| nv_busy | input | 1 | Nonvolatile back end is still storing |
| ack_vld | output | 1 | One-cycle answer to `ev_byte` |
| ack_ok | output | 1 | Acknowledge (1) or refusal (0), valid with `ack_vld` |
| rd_vld | output | 1 | `rd_data` holds the register byte |
| rd_data | output | 8 | Byte returned to the master |
| store_go | output | 1 | One-cycle strobe that starts a nonvolatile store |
| store_img | output | 8 | Persistent image to store (bits 2:1 zero) |
| cfg_q | output | 8 | Current register value, latches included |

## Verification
A lost or spurious arm latch shows up on bit 1 or bit 2 of `cfg_q` on the clock after the stop that should or should not have set it. It also shows up on the next random read, and it decides whether the following write stores anything. A sequencer left in the wrong phase shows up as a wrong acknowledge on the very next byte, or as a read that returns nothing. The bench checks acknowledges, the store strobe and `cfg_q` after every byte and every stop. That is why most faults appear within one transaction.

// File: rtl/cfg_guard_seq.sv
`timescale 1ns/1ps
module cfg_guard_seq #(
  parameter logic [6:0]  DEV_ID   = 7'h50,
  parameter logic [15:0] REG_ADDR = 16'hFFFF,
  parameter logic [7:0]  INIT_IMG = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_byte,
  input  logic [7:0] rx_byte,
  input  logic       ev_rdreq,
  input  logic       nv_busy,
  output logic       ack_vld,
  output logic       ack_ok,
  output logic       rd_vld,
  output logic [7:0] rd_data,
  output logic       store_go,
  output logic [7:0] store_img,
  output logic [7:0] cfg_q
);
  localparam logic [7:0] KEEP_MASK = 8'hF9;
  localparam logic [7:0] ARM1_CODE = 8'h02;
  localparam logic [7:0] ARM2_CODE = 8'h06;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_AHI, S_ALO, S_DATA, S_HOLD, S_RDATA, S_IGN
  } phase_t;

  phase_t     st;
  logic       armed, hi_ok, wr_arm, reg_arm;
  logic [7:0] pimg, pend;

  wire sel_ok = (rx_byte[7:1] == DEV_ID) && !nv_busy && (!rx_byte[0] || armed);

  assign cfg_q = pimg | {5'b0, reg_arm, wr_arm, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      armed     <= 1'b0;
      hi_ok     <= 1'b0;
      wr_arm    <= 1'b0;
      reg_arm   <= 1'b0;
      pimg      <= INIT_IMG & KEEP_MASK;
      pend      <= 8'h00;
      ack_vld   <= 1'b0;
      ack_ok    <= 1'b0;
      rd_vld    <= 1'b0;
      rd_data   <= 8'h00;
      store_go  <= 1'b0;
      store_img <= 8'h00;
    end else begin
      ack_vld  <= 1'b0;
      ack_ok   <= 1'b0;
      rd_vld   <= 1'b0;
      store_go <= 1'b0;
      if (ev_start) begin
        armed <= (st == S_DATA);
        st    <= S_DEV;
      end else if (ev_stop) begin
        if (st == S_HOLD) begin
          if (wr_arm && reg_arm) begin
            pimg      <= pend & KEEP_MASK;
            store_img <= pend & KEEP_MASK;
            store_go  <= 1'b1;
            wr_arm    <= 1'b0;
            reg_arm   <= 1'b0;
          end else if (pend == ARM1_CODE) begin
            wr_arm <= 1'b1;
          end else if (pend == ARM2_CODE && wr_arm) begin
            reg_arm <= 1'b1;
          end
        end
        armed <= 1'b0;
        st    <= S_IDLE;
      end else if (ev_byte) begin
        ack_vld <= 1'b1;
        case (st)
          S_DEV: begin
            armed <= 1'b0;
            if (sel_ok) begin
              ack_ok <= 1'b1;
              st     <= rx_byte[0] ? S_RDATA : S_AHI;
            end else begin
              st <= S_IGN;
            end
          end
          S_AHI: begin
            ack_ok <= 1'b1;
            hi_ok  <= (rx_byte == REG_ADDR[15:8]);
            st     <= S_ALO;
          end
          S_ALO: begin
            ack_ok <= 1'b1;
            st     <= (hi_ok && rx_byte == REG_ADDR[7:0]) ? S_DATA : S_IGN;
          end
          S_DATA: begin
            ack_ok <= 1'b1;
            pend   <= rx_byte;
            st     <= S_HOLD;
          end
          S_RDATA: st <= S_IGN;
          default: ack_ok <= 1'b0;
        endcase
      end else if (ev_rdreq && st == S_RDATA) begin
        rd_vld  <= 1'b1;
        rd_data <= cfg_q;
        st      <= S_IDLE;
      end
    end
  end
endmodule

module cfg_guard_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_byte,
  input logic [7:0] rx_byte,
  input logic       ev_rdreq,
  input logic       nv_busy,
  input logic       ack_vld,
  input logic       ack_ok,
  input logic       rd_vld,
  input logic [7:0] rd_data,
  input logic       store_go,
  input logic [7:0] store_img,
  input logic [7:0] cfg_q
);
  p_store_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |=> !store_go);
  p_store_clears_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |-> (cfg_q[2:1] == 2'b00 && store_img == cfg_q));
  p_store_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |-> $past(ev_stop));
  p_persist_only_by_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q & 8'hF9) |-> store_go);
  p_ack_follows_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> $past(ev_byte));
  p_ack_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |-> ack_vld);
  p_read_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |=> !rd_vld);
  p_read_on_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $past(ev_rdreq));
endmodule

bind cfg_guard_seq cfg_guard_seq_chk u_chk (.*);

// File: tb/cfg_guard_seq_test.sv
`timescale 1ns/1ps
module cfg_guard_seq_test;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, ev_byte = 0, ev_rdreq = 0, nv_busy = 0;
  logic [7:0] rx_byte = 8'h00;
  logic ack_vld, ack_ok, rd_vld, store_go;
  logic [7:0] rd_data, store_img, cfg_q;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] m_img = 8'h00;
  logic m_w = 0, m_r = 0;

  cfg_guard_seq uut (.*);

  always #2 clk = ~clk;

  function automatic logic [7:0] model_cfg();
    return m_img | {5'b0, m_r, m_w, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) ev_start = 1;
    @(negedge clk) ev_start = 0;
  endtask

  task automatic do_stop(output logic sg, output logic [7:0] si);
    @(negedge clk) ev_stop = 1;
    @(negedge clk) ev_stop = 0;
    sg = store_go; si = store_img;
  endtask

  task automatic put(input logic [7:0] b, output logic a);
    @(negedge clk) begin ev_byte = 1; rx_byte = b; end
    @(negedge clk) ev_byte = 0;
    a = ack_vld & ack_ok;
  endtask

  task automatic rdreq(output logic v, output logic [7:0] d);
    @(negedge clk) ev_rdreq = 1;
    @(negedge clk) ev_rdreq = 0;
    v = rd_vld; d = rd_data;
  endtask

  task automatic write_txn(input logic [15:0] addr, input logic [7:0] b, input logic extra);
    logic a, sg, exp_sg;
    logic [7:0] si;
    bit hit;
    hit = (addr == 16'hFFFF);
    do_start();
    put({DEV, 1'b0}, a);      chk(a == 1, "R2 select write", a, 1);
    put(addr[15:8], a);       chk(a == 1, "R3 addr hi", a, 1);
    put(addr[7:0], a);        chk(a == 1, "R3 addr lo", a, 1);
    put(b, a);                chk(a == hit, hit ? "R4 first data" : "R3 data refused", a, hit);
    if (extra) begin
      put(~b, a);             chk(a == 0, "R4 extra data", a, 0);
    end
    do_stop(sg, si);
    exp_sg = 0;
    if (hit) begin
      if (m_w && m_r) begin
        exp_sg = 1; m_img = b & 8'hF9; m_w = 0; m_r = 0;
      end else if (b == 8'h02) m_w = 1;
      else if (b == 8'h06 && m_w) m_r = 1;
    end
    chk(sg == exp_sg, "R7 store strobe", sg, exp_sg);
    if (exp_sg) chk(si == m_img, "R7 store image", si, m_img);
    @(negedge clk);
    chk(store_go == 0, "R7 strobe width", store_go, 0);
    chk(cfg_q == model_cfg(), "R8 register after write", cfg_q, model_cfg());
  endtask

  task automatic read_txn();
    logic a, v;
    logic [7:0] d;
    do_start();
    put({DEV, 1'b0}, a); put(8'hFF, a); put(8'hFF, a);
    do_start();
    put({DEV, 1'b1}, a);  chk(a == 1, "R10 select read", a, 1);
    rdreq(v, d);
    chk(v == 1, "R10 read valid", v, 1);
    chk(d == model_cfg(), "R10 read data", d, model_cfg());
  endtask

  initial begin
    logic a, v, sg;
    logic [7:0] d, si;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_q == 8'h00, "R1 reset value", cfg_q, 0);
    chk({ack_vld, rd_vld, store_go} == 3'b000, "R1 reset outputs", {ack_vld, rd_vld, store_go}, 0);

    read_txn();
    write_txn(16'hFFFF, 8'hA5, 0);   // R8 without latches
    write_txn(16'hFFFF, 8'h06, 0);   // R6 without write-arm
    chk(cfg_q[2] == 0, "R6 ignored", cfg_q[2], 0);
    write_txn(16'hFFFF, 8'h02, 0);   // R5
    chk(cfg_q[1] == 1, "R5 write-arm set", cfg_q[1], 1);
    read_txn();
    write_txn(16'hFFFF, 8'h06, 0);   // R6
    chk(cfg_q[2:1] == 2'b11, "R6 register-arm set", cfg_q[2:1], 3);

    do_start(); put({DEV, 1'b0}, a); put(8'hFF, a); put(8'hFF, a);
    do_stop(sg, si);
    chk(sg == 0 && cfg_q == model_cfg(), "R9 stop before data", cfg_q, model_cfg());
    do_start(); put({DEV, 1'b0}, a); put(8'hFF, a); put(8'hFF, a); put(8'hC3, a);
    do_start(); do_stop(sg, si);
    chk(sg == 0 && cfg_q == model_cfg(), "R9 restart after data", cfg_q, model_cfg());

    write_txn(16'h12FF, 8'h3C, 0);   // R3 wrong address
    write_txn(16'hFFFF, 8'hA5, 1);   // R7 store, R4 extra
    read_txn();

    do_start(); put({DEV, 1'b1}, a);
    chk(a == 0, "R2 read without address", a, 0);
    put(8'hFF, a); chk(a == 0, "R2 refused stays refused", a, 0);
    do_start(); put({~DEV[6], DEV[5:0], 1'b0}, a);
    chk(a == 0, "R2 wrong id", a, 0);
    nv_busy = 1;
    do_start(); put({DEV, 1'b0}, a);
    chk(a == 0, "R2 busy refusal", a, 0);
    nv_busy = 0;
    do_stop(sg, si);

    read_txn();
    rdreq(v, d);  chk(v == 0, "R10 second request empty", v, 0);
    put(8'hFF, a); chk(a == 0, "R10 idle after read", a, 0);
    do_stop(sg, si);

    for (int i = 0; i < 300; i++) begin
      int op;
      logic [7:0] b;
      op = $urandom_range(0, 5);
      b = 8'($urandom);
      case (op)
        0: write_txn(16'hFFFF, 8'h02, 0);
        1: write_txn(16'hFFFF, 8'h06, 0);
        2: write_txn(16'hFFFF, b, $urandom_range(0, 1) == 1);
        3: read_txn();
        4: write_txn(16'hFFFF ^ 16'($urandom_range(1, 65535)), b, 0);
        default: begin
          do_start(); put({DEV, 1'b0}, a); put(8'hFF, a); put(8'hFF, a);
          do_stop(sg, si);
          chk(sg == 0 && cfg_q == model_cfg(), "R9 random abort", cfg_q, model_cfg());
        end
      endcase
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4163));
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule